// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block sequences one DMA channel. Software loads a working descriptor (source address, destination address, unit count) and a shadow descriptor (next source, next destination, next count), together with a chain count. The sequencer then moves one data unit per granted memory request. After each unit it steps both addresses and lowers the count by one. When the count reaches zero, the sequencer either finishes or, if chaining applies, copies the shadow descriptor into the working registers, lowers the chain count and carries on.

The memory side is a simple request/grant port. `mem_req` stays high while a unit is offered, with the current addresses and the size code on `mem_src`, `mem_dst` and `mem_size`. A cycle with `mem_gnt` high completes that unit. Register writes arrive as a strobe, a 3-bit select and a data word. Control bits are static inputs.

A state machine drives the sequence through five states:
- IDLE waits for permission and a request.
- ALIGN checks address alignment.
- BUS holds the memory request.
- UPDATE steps the addresses and the count.
- TALLY decides whether the block ends, the descriptor reloads, or the next unit follows.

The transitions are:
- IDLE→ALIGN on go.
- ALIGN→IDLE on abort or misalignment, otherwise ALIGN→BUS.
- BUS→IDLE on abort.
- BUS→UPDATE on grant.
- UPDATE→TALLY always.
- TALLY→IDLE always.

Top module: `dma_chain_ch`

## Requirements
- R1: A unit is started only while `ch_en` and `master_en` are both 1 and `te_flag`, `nmi_flag` and `ae_flag` are all 0.
- R2: With `auto_req`=1 units start with no request input; with `auto_req`=0 a unit starts only while `dreq` is 1.
- R3: Each granted unit lowers the count by exactly 1; a block ends when the count reaches 0, and a count of 0 starts nothing.
- R4: `unit_size` encodes the unit as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=16 bytes, and is presented on `mem_size` during the request.
- R5: Source and destination step by the unit size after each unit under separate 2-bit modes: 0 fixed, 1 increment, 2 decrement, 3 fixed.
- R6: A rising NMI event (sets `nmi_flag`) or clearing either enable while a request is pending withdraws `mem_req`, and the count is left unchanged.
- R7: If the source or destination is not a multiple of the unit size, `ae_flag` is set, no request is issued, and the addresses do not change.
- R8: When the count reaches 0 with `chain_en`=1, `auto_req`=0 and chain count nonzero, the next source, destination and count are copied to the working registers, the chain count drops by 1, and transfers continue.
- R9: When the count reaches 0 with `auto_req`=1, `chain_en`=0 or chain count 0, no reload happens and `te_flag` is set.
- R10: With `irq_en`=1, a one-cycle `irq` pulse fires at every block end when `end_sel`=1; when `end_sel`=0 it fires only at a block end where the chain count is 0. With `irq_en`=0 no pulse fires.
- R11: `te_flag` stays set and blocks transfers until `clr_flags`, which clears all three flags.
- R12: After reset there is no request, no interrupt, all flags are 0 and all registers are 0.
- R13: Register select codes: 0 source, 1 destination, 2 count, 3 next source, 4 next destination, 5 next count, 6 chain count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | AW | Register write data |
| ch_en | input | 1 | Channel enable |
| master_en | input | 1 | Global master enable |
| auto_req | input | 1 | Auto-request mode |
| dreq | input | 1 | External transfer request |
| chain_en | input | 1 | Chain enable |
| end_sel | input | 1 | Interrupt per block (1) or per chain (0) |
| irq_en | input | 1 | Interrupt enable |
| unit_size | input | 2 | Unit size code |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| nmi_evt | input | 1 | NMI event pulse |
| clr_flags | input | 1 | Clear flags |
| mem_gnt | input | 1 | Memory grant |
| mem_req | output | 1 | Memory request |
| mem_src | output | AW | Current source address |
| mem_dst | output | AW | Current destination address |
| mem_size | output | 2 | Unit size of the request |
| irq | output | 1 | Completion interrupt pulse |
| te_flag | output | 1 | Transfer end flag |
| nmi_flag | output | 1 | NMI suspend flag |
| ae_flag | output | 1 | Address error flag |
| cur_cnt | output | CW | Working count |
| cur_chcnt | output | NW | Chain count |

## Verification
The hardest state to reach is a suspension that lands while a request is pending. It needs a request that has been raised but not granted.

The stimulus holds `mem_gnt` low, so the sequencer parks in BUS. It then fires the NMI event, or drops the channel enable, and confirms that the request goes away and the count stays put. After that it restores the grant and lets the block finish.

Chain behaviour is swept over every chain count from 0 to 3 and both end-select settings. Unit totals, final addresses and interrupt counts are predicted arithmetically.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_BUS,
        ST_UPDATE,
        ST_TALLY
    } seq_state_e;

    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_CNT   = 3'd2;
    localparam logic [2:0] SEL_NSRC  = 3'd3;
    localparam logic [2:0] SEL_NDST  = 3'd4;
    localparam logic [2:0] SEL_NCNT  = 3'd5;
    localparam logic [2:0] SEL_CHCNT = 3'd6;

    localparam logic [1:0] AM_FIXED = 2'd0;
    localparam logic [1:0] AM_INC   = 2'd1;
    localparam logic [1:0] AM_DEC   = 2'd2;

    function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 5'd1;
            2'd1:    return 5'd2;
            2'd2:    return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_chain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cur,
    input  logic          wr_next,
    input  logic [AW-1:0] wr_data,
    input  logic          step,
    input  logic          reload,
    input  logic [1:0]    mode,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr,
    output logic          misalign
);
    logic [AW-1:0] cur_q;
    logic [AW-1:0] nxt_q;
    logic [AW-1:0] step_amt;

    assign step_amt = AW'(unit_bytes(size));
    assign addr     = cur_q;
    assign misalign = |(cur_q & (step_amt - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (reload) begin
            cur_q <= nxt_q;
        end else if (step) begin
            unique case (mode)
                AM_INC:  cur_q <= cur_q + step_amt;
                AM_DEC:  cur_q <= cur_q - step_amt;
                default: cur_q <= cur_q;
            endcase
        end else if (wr_cur) begin
            cur_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       nxt_q <= '0;
        else if (wr_next) nxt_q <= wr_data;
    end

    // R5: fixed modes leave the address alone
    p_fixed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload && (mode == AM_FIXED || mode == 2'd3)) |=> (addr == $past(addr)));

    // R5: increment mode adds the unit size
    p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload && mode == AM_INC) |=> (addr == $past(addr) + $past(step_amt)));

    // R8: reload takes the shadow address
    p_reload_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (addr == $past(nxt_q)));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cnt,
    input  logic          wr_ncnt,
    input  logic          wr_chcnt,
    input  logic [CW-1:0] wr_cdata,
    input  logic [NW-1:0] wr_ndata,
    input  logic          dec,
    input  logic          reload,
    output logic [CW-1:0] cnt,
    output logic [NW-1:0] chcnt,
    output logic          cnt_zero,
    output logic          chcnt_zero
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ncnt_q;
    logic [NW-1:0] chcnt_q;

    assign cnt        = cnt_q;
    assign chcnt      = chcnt_q;
    assign cnt_zero   = (cnt_q == '0);
    assign chcnt_zero = (chcnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (reload)  cnt_q <= ncnt_q;
        else if (dec)     cnt_q <= cnt_q - 1'b1;
        else if (wr_cnt)  cnt_q <= wr_cdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ncnt_q <= '0;
        else if (wr_ncnt) ncnt_q <= wr_cdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chcnt_q <= '0;
        else if (reload)   chcnt_q <= chcnt_q - 1'b1;
        else if (wr_chcnt) chcnt_q <= wr_ndata;
    end

    // R3: one unit lowers the count by one
    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !reload) |=> (cnt == $past(cnt) - 1'b1));

    // R8: reload takes shadow count and lowers chain count
    p_chain_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (chcnt == $past(chcnt) - 1'b1 && cnt == $past(ncnt_q)));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ch_en,
    input  logic master_en,
    input  logic auto_req,
    input  logic dreq,
    input  logic chain_en,
    input  logic end_sel,
    input  logic irq_en,
    input  logic nmi_evt,
    input  logic clr_flags,
    input  logic mem_gnt,
    input  logic misalign,
    input  logic cnt_zero,
    input  logic chcnt_zero,
    output logic mem_req,
    output logic step,
    output logic reload,
    output logic irq,
    output logic te_flag,
    output logic nmi_flag,
    output logic ae_flag
);
    seq_state_e state_q, state_d;
    logic run_ok;
    logic chain_go;
    logic set_te;
    logic set_ae;

    assign run_ok   = ch_en && master_en && !te_flag && !nmi_flag && !ae_flag;
    assign chain_go = chain_en && !auto_req && !chcnt_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run_ok && (auto_req || dreq) && !cnt_zero) state_d = ST_ALIGN;
            ST_ALIGN:  state_d = (!run_ok || misalign) ? ST_IDLE : ST_BUS;
            ST_BUS: begin
                if (!run_ok)      state_d = ST_IDLE;
                else if (mem_gnt) state_d = ST_UPDATE;
            end
            ST_UPDATE: state_d = ST_TALLY;
            ST_TALLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        step    = 1'b0;
        reload  = 1'b0;
        irq     = 1'b0;
        set_te  = 1'b0;
        set_ae  = 1'b0;
        unique case (state_q)
            ST_ALIGN:  set_ae  = run_ok && misalign;
            ST_BUS:    mem_req = 1'b1;
            ST_UPDATE: step    = 1'b1;
            ST_TALLY: begin
                if (cnt_zero) begin
                    reload = chain_go;
                    set_te = !chain_go;
                    irq    = irq_en && (chain_go ? end_sel : (end_sel || chcnt_zero));
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            te_flag  <= 1'b0;
            nmi_flag <= 1'b0;
            ae_flag  <= 1'b0;
        end else begin
            te_flag  <= set_te  || (te_flag  && !clr_flags);
            nmi_flag <= nmi_evt || (nmi_flag && !clr_flags);
            ae_flag  <= set_ae  || (ae_flag  && !clr_flags);
        end
    end

    // R6: a pending request is withdrawn once permission is lost
    p_suspend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !run_ok) |=> !mem_req);

    // R7: no request on a misaligned address
    p_req_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !misalign);

    // R7: an address error blocks requests
    p_ae_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ae_flag |-> !mem_req);

    // R11: transfer end flag is sticky
    p_te_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (te_flag && !clr_flags) |=> te_flag);

    // R10: interrupt is a single-cycle pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: rtl/dma_chain_ch.sv
module dma_chain_ch
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          ch_en,
    input  logic          master_en,
    input  logic          auto_req,
    input  logic          dreq,
    input  logic          chain_en,
    input  logic          end_sel,
    input  logic          irq_en,
    input  logic [1:0]    unit_size,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic          nmi_evt,
    input  logic          clr_flags,
    input  logic          mem_gnt,
    output logic          mem_req,
    output logic [AW-1:0] mem_src,
    output logic [AW-1:0] mem_dst,
    output logic [1:0]    mem_size,
    output logic          irq,
    output logic          te_flag,
    output logic          nmi_flag,
    output logic          ae_flag,
    output logic [CW-1:0] cur_cnt,
    output logic [NW-1:0] cur_chcnt
);
    localparam int NADDR = 2;

    logic step, reload, cnt_zero, chcnt_zero;
    logic [AW-1:0] addr_w  [NADDR];
    logic          misal_w [NADDR];
    logic [1:0]    mode_w  [NADDR];

    assign mode_w[0] = src_mode;
    assign mode_w[1] = dst_mode;

    for (genvar g = 0; g < NADDR; g++) begin : g_addr
        localparam logic [2:0] CUR_SEL = (g == 0) ? SEL_SRC  : SEL_DST;
        localparam logic [2:0] NXT_SEL = (g == 0) ? SEL_NSRC : SEL_NDST;
        dma_addr_unit #(.AW(AW)) addr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cur   (reg_we && reg_sel == CUR_SEL),
            .wr_next  (reg_we && reg_sel == NXT_SEL),
            .wr_data  (reg_wdata),
            .step     (step),
            .reload   (reload),
            .mode     (mode_w[g]),
            .size     (unit_size),
            .addr     (addr_w[g]),
            .misalign (misal_w[g])
        );
    end

    dma_count_unit #(.CW(CW), .NW(NW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cnt     (reg_we && reg_sel == SEL_CNT),
        .wr_ncnt    (reg_we && reg_sel == SEL_NCNT),
        .wr_chcnt   (reg_we && reg_sel == SEL_CHCNT),
        .wr_cdata   (reg_wdata[CW-1:0]),
        .wr_ndata   (reg_wdata[NW-1:0]),
        .dec        (step),
        .reload     (reload),
        .cnt        (cur_cnt),
        .chcnt      (cur_chcnt),
        .cnt_zero   (cnt_zero),
        .chcnt_zero (chcnt_zero)
    );

    dma_seq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_en      (ch_en),
        .master_en  (master_en),
        .auto_req   (auto_req),
        .dreq       (dreq),
        .chain_en   (chain_en),
        .end_sel    (end_sel),
        .irq_en     (irq_en),
        .nmi_evt    (nmi_evt),
        .clr_flags  (clr_flags),
        .mem_gnt    (mem_gnt),
        .misalign   (misal_w[0] || misal_w[1]),
        .cnt_zero   (cnt_zero),
        .chcnt_zero (chcnt_zero),
        .mem_req    (mem_req),
        .step       (step),
        .reload     (reload),
        .irq        (irq),
        .te_flag    (te_flag),
        .nmi_flag   (nmi_flag),
        .ae_flag    (ae_flag)
    );

    assign mem_src  = addr_w[0];
    assign mem_dst  = addr_w[1];
    assign mem_size = unit_size;

    // R3: count never changes while a request waits
    p_req_count_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(cur_cnt));

endmodule

// File: tb/dma_chain_ch_tb_top.sv
module dma_chain_ch_tb_top;
    localparam int AW = 32, CW = 16, NW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 0; logic [2:0] reg_sel = 0; logic [AW-1:0] reg_wdata = 0;
    logic ch_en = 0, master_en = 0, auto_req = 0, dreq = 0, chain_en = 0;
    logic end_sel = 0, irq_en = 0, nmi_evt = 0, clr_flags = 0, mem_gnt = 1;
    logic [1:0] unit_size = 0, src_mode = 0, dst_mode = 0;
    logic mem_req, irq, te_flag, nmi_flag, ae_flag;
    logic [AW-1:0] mem_src, mem_dst;
    logic [1:0] mem_size;
    logic [CW-1:0] cur_cnt;
    logic [NW-1:0] cur_chcnt;

    int n_chk = 0, n_fail = 0, units = 0, irqs = 0, cycles = 0;
    logic [1:0] last_size = 0;

    always #10 clk = ~clk;

    dma_chain_ch #(.AW(AW), .CW(CW), .NW(NW)) dut_i (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_gnt) begin
            units <= units + 1;
            last_size <= mem_size;
        end
        if (irq) irqs <= irqs + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic clr();
        @(negedge clk); clr_flags = 1;
        @(negedge clk); clr_flags = 0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!(te_flag || ae_flag) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        cyc(2);
    endtask

    function automatic longint step_addr(longint a, int mode, int sz, int n);
        int b = (sz == 3) ? 16 : (1 << sz);
        if (mode == 1) return (a + b * n) & 32'hFFFF_FFFF;
        if (mode == 2) return (a - b * n) & 32'hFFFF_FFFF;
        return a;
    endfunction

    initial begin
        int u0, i0;
        cyc(3);
        // R12: reset state
        chk(mem_req == 0 && irq == 0, "R12 outputs", mem_req, 0);
        chk(!te_flag && !nmi_flag && !ae_flag, "R12 flags", {te_flag, nmi_flag, ae_flag}, 0);
        chk(cur_cnt == 0 && mem_src == 0, "R12 regs", cur_cnt, 0);
        rst_n = 1;
        cyc(2);

        // R1 gating; R13 select codes
        wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 2);
        chk(mem_src == 32'h100 && mem_dst == 32'h200 && cur_cnt == 2, "R13 writes", mem_src, 32'h100);
        auto_req = 1; master_en = 1; ch_en = 0; cyc(10);
        chk(units == 0, "R1 channel disabled", units, 0);
        ch_en = 1; master_en = 0; cyc(10);
        chk(units == 0, "R1 master disabled", units, 0);
        master_en = 1; wait_end();
        chk(units == 2, "R3 unit total", units, 2);
        chk(cur_cnt == 0, "R3 count zero", cur_cnt, 0);
        chk(te_flag == 1, "R9 end flag", te_flag, 1);

        // R11: te blocks until cleared
        wr(3'd2, 2); cyc(10);
        chk(units == 2 && cur_cnt == 2, "R11 te blocks", units, 2);
        clr(); wait_end();
        chk(units == 4, "R11 resumes after clear", units, 4);

        // R3: zero count starts nothing
        wr(3'd2, 0); clr(); cyc(10);
        chk(units == 4 && !te_flag, "R3 zero count idle", units, 4);
        ch_en = 0;

        // R2: request mode
        auto_req = 0; dreq = 0; wr(3'd2, 2); ch_en = 1; cyc(10);
        chk(units == 4, "R2 no dreq", units, 4);
        dreq = 1; wait_end();
        chk(units == 6, "R2 dreq starts", units, 6);
        auto_req = 1; dreq = 0;

        // R4 R5: sweep size and both address modes
        for (int sz = 0; sz < 4; sz++)
            for (int sm = 0; sm < 4; sm++)
                for (int dm = 0; dm < 4; dm++) begin
                    unit_size = 2'(sz); src_mode = 2'(sm); dst_mode = 2'(dm);
                    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 3);
                    u0 = units;
                    clr(); wait_end();
                    chk(units == u0 + 3, "R3 sweep units", units, u0 + 3);
                    chk(last_size == 2'(sz), "R4 mem_size", last_size, sz);
                    chk(mem_src == 32'(step_addr(32'h1000, sm, sz, 3)), "R5 source step",
                        mem_src, step_addr(32'h1000, sm, sz, 3));
                    chk(mem_dst == 32'(step_addr(32'h2000, dm, sz, 3)), "R5 destination step",
                        mem_dst, step_addr(32'h2000, dm, sz, 3));
                end

        // R7: misalignment
        for (int sz = 1; sz < 4; sz++) begin
            unit_size = 2'(sz); src_mode = 1; dst_mode = 1;
            wr(3'd0, 32'h1001); wr(3'd1, 32'h2000); wr(3'd2, 2);
            u0 = units;
            clr(); wait_end();
            chk(ae_flag == 1, "R7 error flag", ae_flag, 1);
            chk(units == u0 && mem_src == 32'h1001 && cur_cnt == 2, "R7 nothing moved", mem_src, 32'h1001);
        end
        unit_size = 0;

        // R8 R9 R10: chain sweep
        auto_req = 0; dreq = 1; chain_en = 1; irq_en = 1;
        for (int chc = 0; chc < 4; chc++)
            for (int es = 0; es < 2; es++) begin
                end_sel = es[0];
                wr(3'd0, 32'h100); wr(3'd1, 32'h800); wr(3'd2, 2);
                wr(3'd3, 32'h400); wr(3'd4, 32'hC00); wr(3'd5, 3); wr(3'd6, 32'(chc));
                u0 = units; i0 = irqs;
                clr(); wait_end();
                chk(units == u0 + 2 + 3 * chc, "R8 chained units", units - u0, 2 + 3 * chc);
                chk(mem_src == ((chc == 0) ? 32'h102 : 32'h403), "R8 reloaded source", mem_src,
                    (chc == 0) ? 32'h102 : 32'h403);
                chk(mem_dst == ((chc == 0) ? 32'h802 : 32'hC03), "R8 reloaded destination", mem_dst,
                    (chc == 0) ? 32'h802 : 32'hC03);
                chk(cur_chcnt == 0, "R8 chain count down", cur_chcnt, 0);
                chk(irqs == i0 + (es ? 1 + chc : 1), "R10 interrupt count", irqs - i0, es ? 1 + chc : 1);
            end

        // R9: auto mode does not reload
        auto_req = 1; end_sel = 1;
        wr(3'd0, 32'h100); wr(3'd2, 2); wr(3'd6, 2);
        u0 = units; i0 = irqs;
        clr(); wait_end();
        chk(units == u0 + 2 && cur_chcnt == 2, "R9 auto no reload", cur_chcnt, 2);
        chk(irqs == i0 + 1, "R10 auto end interrupt", irqs - i0, 1);

        // R10: interrupt disabled
        irq_en = 0; wr(3'd2, 2); i0 = irqs;
        clr(); wait_end();
        chk(irqs == i0, "R10 masked", irqs - i0, 0);
        chain_en = 0;

        // R6: suspension with pending request
        mem_gnt = 0; wr(3'd2, 3); u0 = units;
        clr(); cyc(4);
        chk(mem_req == 1, "R6 request pending", mem_req, 1);
        @(negedge clk) nmi_evt = 1;
        @(negedge clk) nmi_evt = 0;
        cyc(3);
        chk(mem_req == 0 && nmi_flag == 1, "R6 nmi withdraws", mem_req, 0);
        chk(cur_cnt == 3, "R6 nmi count kept", cur_cnt, 3);
        clr(); cyc(4);
        chk(mem_req == 1, "R6 request again", mem_req, 1);
        ch_en = 0; cyc(3);
        chk(mem_req == 0 && cur_cnt == 3, "R6 enable drop withdraws", mem_req, 0);
        mem_gnt = 1; ch_en = 1; wait_end();
        chk(units == u0 + 3, "R6 resumes to end", units - u0, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule